// File: doc/BRIEF.md
# Hot-Add CPU Presence Map

This block keeps one presence flag for each CPU slot, and a slot's APIC ID is the index of its flag. When the platform reports that a CPU has been hot-added, the block sets that CPU's flag. It also latches a general-purpose event status flag (event bit 2), which drives the system control interrupt request. Firmware reads the map one byte at a time through a small host port. Byte `n` of the window holds the flags for APIC IDs `8n` to `8n+7`, and bit `k` of that byte belongs to APIC ID `8n+k`. Nothing the host does can clear a flag, and no event clears one either.

Under normal use the map cannot be written. Its one write function is a one-way switch. When zero has been written to all four bytes of the first 32-bit word (bytes 0 to 3), the block leaves legacy mode and reports this on `legacyMode`. Control then passes to a newer hotplug register set, which sits outside this block. Firmware clears the event status through a separate clear pulse.

Top module: `hotadd_present_map`

## Requirements
- R1: After reset, every map byte reads 0x00, `legacyMode` is 1, and `gpeSts` and `sciReq` are 0.
- R2: A hot-add with an APIC ID below `NUM_CPUS` sets bit `id%8` of map byte `id/8`, counted from the first clock edge on which the event is sampled.
- R3: No host write and no event ever clears a presence bit. A write of 0xFF to a byte leaves its contents unchanged.
- R4: An accepted hot-add sets `gpeSts` at the same clock edge. `sciReq` always equals `gpeSts`.
- R5: A `gpeClr` pulse clears `gpeSts` at the next edge. If an accepted hot-add arrives in the same cycle, the hot-add wins and `gpeSts` stays 1.
- R6: A hot-add with an APIC ID of `NUM_CPUS` or above is dropped, and `gpeSts` is not raised. Bits for APIC IDs of `NUM_CPUS` or above always read 0, anywhere in the 32-byte window.
- R7: A read strobe at one edge gives the addressed byte on `hostRdata`, with `hostRdValid` high, after that edge and for one cycle.
- R8: `legacyMode` drops to 0 at the edge of the write that completes a set of zero-valued writes to each of bytes 0, 1, 2 and 3, in any order.
- R9: A nonzero write to any of bytes 0 to 3 discards the zero-write progress made so far. Writes to bytes 4 to 31 neither count toward the switch nor discard the progress.
- R10: Once `legacyMode` is 0, it stays 0 until reset, and further host writes have no effect.
- R11: Hot-add events are still recorded, and still raise `gpeSts`, after the switch out of legacy mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hotAddValid | input | 1 | Hot-add event strobe |
| hotAddId | input | 8 | APIC ID of the hot-added CPU |
| gpeClr | input | 1 | Pulse that clears the event status |
| hostAddr | input | 5 | Byte address within the map window |
| hostRd | input | 1 | Byte read strobe |
| hostWr | input | 1 | Byte write strobe |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data, registered |
| hostRdValid | output | 1 | Read data valid |
| gpeSts | output | 1 | Event bit 2 status |
| sciReq | output | 1 | Interrupt request, follows `gpeSts` |
| legacyMode | output | 1 | 1 while the legacy map interface is active |

## Verification
The map is read with hot-adds at the lowest ID, at an ID in the middle of a byte and at the highest populated ID. This separates errors in the byte index from errors in the bit index. An out-of-range ID and reads of the unpopulated bytes test the population limit. The mode switch is driven with zero writes out of order, interrupted by a nonzero write and interleaved with writes outside the first word. These sequences separate a correct four-byte tracker from one that counts writes, keys on a single byte, or ignores resets of its progress. Clear and hot-add pulses in the same cycle check the priority on the status flag.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int APIC_W    = 8;
  localparam int WIN_BYTES = (1 << APIC_W) / 8;
  localparam int WIN_AW    = $clog2(WIN_BYTES);
  localparam int WORD0_B   = 4;

  typedef struct packed {
    logic              setEn;
    logic [APIC_W-1:0] setIdx;
    logic              rdEn;
    logic [WIN_AW-1:0] rdByte;
  } dpCtl_t;
endpackage

// File: rtl/cpm_control.sv
module cpm_control
  import cpm_pkg::*;
#(
  parameter int NUM_CPUS = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hotAddValid,
  input  logic [APIC_W-1:0] hotAddId,
  input  logic              gpeClr,
  input  logic [WIN_AW-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [7:0]        hostWdata,
  output dpCtl_t            dpCtl,
  output logic              gpeSts,
  output logic              legacyMode
);
  localparam logic [APIC_W:0] CPU_LIM = (APIC_W+1)'(NUM_CPUS);

  logic              addOk;
  logic              inWord0;
  logic [WORD0_B-1:0] zeroSeen;
  logic [WORD0_B-1:0] zeroNext;
  logic [WORD0_B-1:0] hitMask;

  assign addOk   = hotAddValid && ({1'b0, hotAddId} < CPU_LIM);
  assign inWord0 = (hostAddr < WIN_AW'(WORD0_B));

  for (genvar i = 0; i < WORD0_B; i++) begin : g_hit
    assign hitMask[i] = (hostAddr == WIN_AW'(i));
  end

  always_comb begin
    zeroNext = zeroSeen;
    if (legacyMode && hostWr && inWord0) begin
      if (hostWdata == 8'h00) zeroNext = zeroSeen | hitMask;
      else                    zeroNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroSeen   <= '0;
      legacyMode <= 1'b1;
    end else begin
      zeroSeen <= zeroNext;
      if (legacyMode && (&zeroNext)) legacyMode <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       gpeSts <= 1'b0;
    else if (addOk)  gpeSts <= 1'b1;
    else if (gpeClr) gpeSts <= 1'b0;
  end

  always_comb begin
    dpCtl.setEn  = addOk;
    dpCtl.setIdx = hotAddId;
    dpCtl.rdEn   = hostRd;
    dpCtl.rdByte = hostAddr;
  end

  a_r4_gpe_after_add: assert property (@(posedge clk) disable iff (!rstN)
    (hotAddValid && ({1'b0, hotAddId} < CPU_LIM)) |=> gpeSts);
  a_r5_clr_wins_alone: assert property (@(posedge clk) disable iff (!rstN)
    (gpeClr && !hotAddValid) |=> !gpeSts);
  a_r10_mode_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !legacyMode |=> !legacyMode);
  a_r9_nonzero_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (legacyMode && hostWr && inWord0 && hostWdata != 8'h00) |=> legacyMode);
endmodule

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int NUM_CPUS = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     dpCtl,
  output logic [7:0] rdData,
  output logic       rdValid
);
  logic [NUM_CPUS-1:0] present;
  logic [7:0]          byteArr [WIN_BYTES];

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) present[i] <= 1'b0;
      else if (dpCtl.setEn && dpCtl.setIdx == APIC_W'(i)) present[i] <= 1'b1;
    end
  end

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      if (b * 8 + k < NUM_CPUS) begin : g_pop
        assign byteArr[b][k] = present[b*8+k];
      end else begin : g_empty
        assign byteArr[b][k] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= dpCtl.rdEn;
      if (dpCtl.rdEn) rdData <= byteArr[dpCtl.rdByte];
    end
  end

  a_r3_never_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ($past(present) & ~present) == '0);
  a_r7_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.rdEn |=> rdValid);
  a_r2_bit_set: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.setEn |=> present != '0);
endmodule

// File: rtl/hotadd_present_map.sv
module hotadd_present_map #(
  parameter int NUM_CPUS = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hotAddValid,
  input  logic [7:0] hotAddId,
  input  logic       gpeClr,
  input  logic [4:0] hostAddr,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic       hostRdValid,
  output logic       gpeSts,
  output logic       sciReq,
  output logic       legacyMode
);
  import cpm_pkg::*;

  initial begin
    if (NUM_CPUS < 1 || NUM_CPUS > (1 << APIC_W))
      $error("NUM_CPUS out of range");
  end

  dpCtl_t dpCtl;

  cpm_control #(.NUM_CPUS(NUM_CPUS)) uCtl (
    .clk(clk), .rstN(rstN),
    .hotAddValid(hotAddValid), .hotAddId(hotAddId), .gpeClr(gpeClr),
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr), .hostWdata(hostWdata),
    .dpCtl(dpCtl), .gpeSts(gpeSts), .legacyMode(legacyMode)
  );

  cpm_datapath #(.NUM_CPUS(NUM_CPUS)) uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl),
    .rdData(hostRdata), .rdValid(hostRdValid)
  );

  assign sciReq = gpeSts;

  a_r4_sci_follows: assert property (@(posedge clk) disable iff (!rstN)
    sciReq == gpeSts);
endmodule

// File: tb/hotadd_present_map_test.sv
module hotadd_present_map_test;
  localparam int NCPU = 48;

  logic clk = 0;
  logic rstN = 0;
  logic hotAddValid = 0;
  logic [7:0] hotAddId = 0;
  logic gpeClr = 0;
  logic [4:0] hostAddr = 0;
  logic hostRd = 0, hostWr = 0;
  logic [7:0] hostWdata = 0;
  logic [7:0] hostRdata;
  logic hostRdValid, gpeSts, sciReq, legacyMode;

  int nRun = 0, nFail = 0;
  logic [255:0] expMap = '0;
  logic [7:0] expQ [$];
  string tagQ [$];
  bit done = 0;

  always #2.5 clk = ~clk;

  hotadd_present_map #(.NUM_CPUS(NCPU)) uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (hostRdValid) begin
      if (expQ.size() == 0) check("R7 unexpected read data", 1, 0);
      else check(tagQ.pop_front(), hostRdata, expQ.pop_front());
    end
  end

  task automatic readByte(int a, string tag);
    @(negedge clk);
    hostRd = 1; hostAddr = 5'(a);
    expQ.push_back(expMap[a*8 +: 8]); tagQ.push_back(tag);
    @(negedge clk);
    hostRd = 0;
  endtask

  task automatic writeByte(int a, logic [7:0] d);
    @(negedge clk);
    hostWr = 1; hostAddr = 5'(a); hostWdata = d;
    @(negedge clk);
    hostWr = 0;
  endtask

  task automatic hotAdd(int id, bit clr);
    @(negedge clk);
    hotAddValid = 1; hotAddId = 8'(id); gpeClr = clr;
    if (id < NCPU) expMap[id] = 1'b1;
    @(negedge clk);
    hotAddValid = 0; gpeClr = 0;
  endtask

  task automatic clearGpe();
    @(negedge clk); gpeClr = 1;
    @(negedge clk); gpeClr = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; expMap = '0;
    repeat (2) @(negedge clk); rstN = 1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    check("R1 legacyMode", legacyMode, 1);
    check("R1 gpeSts", gpeSts, 0);
    check("R1 sciReq", sciReq, 0);
    for (int a = 0; a < 6; a++) readByte(a, "R1 map zero");

    hotAdd(0, 0);
    check("R4 gpeSts after add", gpeSts, 1);
    check("R4 sciReq after add", sciReq, 1);
    hotAdd(9, 0);
    hotAdd(47, 0);
    readByte(0, "R2 id0");
    readByte(1, "R2 id9");
    readByte(5, "R2 id47");

    clearGpe();
    check("R5 clear", gpeSts, 0);
    hotAdd(30, 1);
    check("R5 add wins over clear", gpeSts, 1);
    clearGpe();
    hotAdd(48, 0);
    check("R6 out-of-range no gpe", gpeSts, 0);
    readByte(6, "R6 id48 dropped");
    readByte(31, "R6 top byte zero");
    readByte(3, "R2 id30");

    writeByte(0, 8'hFF);
    writeByte(1, 8'h00);
    readByte(0, "R3 write no change b0");
    readByte(1, "R3 write no change b1");

    writeByte(0, 8'h00); writeByte(1, 8'h00); writeByte(2, 8'h00);
    writeByte(3, 8'h5A);
    @(negedge clk); check("R9 nonzero resets", legacyMode, 1);
    writeByte(3, 8'h00); writeByte(7, 8'h00); writeByte(0, 8'h00);
    writeByte(20, 8'h33); writeByte(1, 8'h00);
    @(negedge clk); check("R9 progress partial", legacyMode, 1);
    writeByte(2, 8'h00);
    @(negedge clk); check("R8 switch out", legacyMode, 0);
    readByte(0, "R3 map kept after switch");

    writeByte(0, 8'h11); writeByte(3, 8'hFF);
    @(negedge clk); check("R10 sticky", legacyMode, 0);
    readByte(0, "R10 writes ignored");
    clearGpe();
    hotAdd(20, 0);
    check("R11 gpe after switch", gpeSts, 1);
    readByte(2, "R11 id20 recorded");

    doReset();
    @(negedge clk);
    check("R1 legacy after reset", legacyMode, 1);
    check("R1 gpe after reset", gpeSts, 0);
    readByte(0, "R1 map cleared");
    readByte(5, "R1 map cleared hi");

    repeat (3) @(negedge clk);
    check("R7 all reads returned", expQ.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule